// File: doc/BRIEF.md
# Flow-through late-write synchronous SRAM

This block is a single-port synchronous SRAM with a flow-through read path and a late-write data path. Every command is registered on the rising clock edge. Read data is not re-registered: it appears on the output bus during the cycle that follows the edge that accepted the read. Write data trails its command by one accepted edge. This lets a host issue reads and writes in any mix on consecutive cycles without idle turnaround cycles on the shared data bus.

A command is either a load or an advance. A load carries a fresh address, a read/write choice and three chip selects. An advance steps a two-bit burst counter over the low address bits in linear or interleaved order and repeats the operation type of the last load. A clock-enable input freezes the whole pipeline. A snooze input does the same and also releases the bus. An asynchronous output enable gates the bus driver without waiting for a clock. Written bytes are held for one cycle in a commit register before they reach the array. Reads of that address in the meantime are merged lane by lane from the commit register.

Top module: `ftsram_top`

## Requirements
- R1: A load (adv_ld=0) accepted with ce_a_n=0, ce_b=1, ce_c_n=0 and rd_wr=1 starts a read. In the following cycle dq_out carries the word at that address, and dq_oe is 1 while oe_n=0.
- R2: A load accepted with all selects active and rd_wr=0 starts a write. The word on dq_in at the next accepted edge is stored. Only the lanes whose byte_we bit is 1 change, where bit i covers dq_in[8i+7:8i].
- R3: A load with any chip select inactive is a deselect: dq_oe stays 0 in the next cycle and nothing is written.
- R4: On an advance (adv_ld=1), rd_wr and the chip selects are ignored. The previous operation type continues, including a deselect. byte_we is sampled again for every write beat.
- R5: The word address of beat n (n = 0..3, wrapping) keeps the upper bits of the load address. Its two low bits are (start + n) mod 4 when lin_burst=1 and start XOR n when lin_burst=0.
- R6: At an edge with cke_n=1 no command is accepted and no write data is captured. Pipeline state and read output hold.
- R7: oe_n acts without a clock: dq_oe falls and rises with it within the cycle.
- R8: While sleep=1, dq_oe is 0, clock edges are ignored and stored data is kept. After sleep returns to 0 the held read drives again.
- R9: A read issued on the edge that captures the data of a write to the same address returns the new bytes in enabled lanes and the older bytes elsewhere.
- R10: Reads and writes can alternate on consecutive accepted edges with no idle cycles, and every read returns the latest data.
- R11: A synchronous reset (rst=1) makes the device idle with dq_oe=0 and discards any pending write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| cke_n | input | 1 | Clock enable, high stalls |
| addr | input | ADDR_W | Word address taken on loads |
| adv_ld | input | 1 | 1 = advance burst, 0 = load |
| rd_wr | input | 1 | On a load: 1 = read, 0 = write |
| byte_we | input | LANES | Per-lane write enable, active high |
| ce_a_n | input | 1 | Chip select, active low |
| ce_b | input | 1 | Chip select, active high |
| ce_c_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Asynchronous output enable, active low |
| lin_burst | input | 1 | Static burst order, 1 = linear, 0 = interleaved |
| sleep | input | 1 | Snooze request, active high |
| dq_in | input | LANES*LANE_W | Write data from the bus |
| dq_out | output | LANES*LANE_W | Flow-through read data |
| dq_oe | output | 1 | Bus driver enable |

## Verification
On every cycle the assertions check how accepted commands map onto the operation state: a selected load becomes a read or a write, a deselect becomes idle, an advance keeps the previous type, and a stalled or sleeping edge changes nothing. They also check that reset clears the pending write, that a write beat always leaves captured data behind it, and that the bus driver never turns on while oe_n or sleep is blocking it. The actual data values can only be shown by the bench scenarios. These cover burst address order in both modes, byte-lane merging on a read that follows a write at once, alternating read/write traffic, writes lost to a stall, a deselect or sleep, and the mid-cycle response to oe_n and sleep.

// File: rtl/ftsram_pkg.sv
`timescale 1ns/1ps
package ftsram_pkg;
  localparam int BURST_W = 2;

  typedef enum logic [1:0] {
    OP_IDLE  = 2'd0,
    OP_READ  = 2'd1,
    OP_WRITE = 2'd2
  } op_e;

  // low address bits of beat 'step' in a four-beat burst
  function automatic logic [BURST_W-1:0] burst_lsb(
    input logic [BURST_W-1:0] start,
    input logic [BURST_W-1:0] step,
    input logic               linear
  );
    return linear ? (start + step) : (start ^ step);
  endfunction
endpackage

// File: rtl/ftsram_cmd.sv
`timescale 1ns/1ps
module ftsram_cmd
  import ftsram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              go,
  input  logic              adv_ld,
  input  logic              rd_wr,
  input  logic              sel_ok,
  input  logic              lin_burst,
  input  logic [ADDR_W-1:0] addr,
  input  logic [LANES-1:0]  byte_we,
  output op_e               op_q,
  output logic [ADDR_W-1:0] cur_addr,
  output logic [LANES-1:0]  cur_be
);
  logic [ADDR_W-1:0]  base_q;
  logic [BURST_W-1:0] step_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      op_q   <= OP_IDLE;
      base_q <= '0;
      step_q <= '0;
      cur_be <= '0;
    end else if (go) begin
      if (!adv_ld) begin
        base_q <= addr;
        step_q <= '0;
        if (!sel_ok)    op_q <= OP_IDLE;
        else if (rd_wr) op_q <= OP_READ;
        else            op_q <= OP_WRITE;
      end else begin
        step_q <= step_q + 1'b1;
      end
      cur_be <= byte_we;
    end
  end

  assign cur_addr = {base_q[ADDR_W-1:BURST_W],
                     burst_lsb(base_q[BURST_W-1:0], step_q, lin_burst)};
endmodule

// File: rtl/ftsram_wbuf.sv
`timescale 1ns/1ps
module ftsram_wbuf #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    go,
  input  logic                    wr_beat,
  input  logic [ADDR_W-1:0]       beat_addr,
  input  logic [LANES-1:0]        beat_be,
  input  logic [LANES*LANE_W-1:0] din,
  input  logic [ADDR_W-1:0]       rd_addr,
  input  logic [LANES*LANE_W-1:0] arr_q,
  output logic                    commit,
  output logic                    pend,
  output logic [ADDR_W-1:0]       cm_addr,
  output logic [LANES-1:0]        cm_be,
  output logic [LANES*LANE_W-1:0] cm_data,
  output logic [LANES*LANE_W-1:0] rd_data
);
  logic hit;

  always_ff @(posedge clk) begin
    if (rst) pend <= 1'b0;
    else if (go) pend <= wr_beat;
  end

  always_ff @(posedge clk) begin
    if (go && wr_beat) begin
      cm_addr <= beat_addr;
      cm_be   <= beat_be;
      cm_data <= din;
    end
  end

  assign commit = go && pend;
  assign hit    = pend && (cm_addr == rd_addr);

  for (genvar l = 0; l < LANES; l++) begin : g_fwd
    assign rd_data[l*LANE_W +: LANE_W] = (hit && cm_be[l]) ? cm_data[l*LANE_W +: LANE_W]
                                                           : arr_q[l*LANE_W +: LANE_W];
  end
endmodule

// File: rtl/ftsram_array.sv
`timescale 1ns/1ps
module ftsram_array #(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    we,
  input  logic [ADDR_W-1:0]       waddr,
  input  logic [LANES-1:0]        wbe,
  input  logic [LANES*LANE_W-1:0] wdata,
  input  logic [ADDR_W-1:0]       raddr,
  output logic [LANES*LANE_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [LANE_W-1:0] bank [DEPTH];

    always_ff @(posedge clk) begin
      if (we && wbe[l]) bank[waddr] <= wdata[l*LANE_W +: LANE_W];
    end

    assign rdata[l*LANE_W +: LANE_W] = bank[raddr];
  end
endmodule

// File: rtl/ftsram_top.sv
`timescale 1ns/1ps
module ftsram_top
  import ftsram_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int LANES  = 4,
  parameter int LANE_W = 8
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    cke_n,
  input  logic [ADDR_W-1:0]       addr,
  input  logic                    adv_ld,
  input  logic                    rd_wr,
  input  logic [LANES-1:0]        byte_we,
  input  logic                    ce_a_n,
  input  logic                    ce_b,
  input  logic                    ce_c_n,
  input  logic                    oe_n,
  input  logic                    lin_burst,
  input  logic                    sleep,
  input  logic [LANES*LANE_W-1:0] dq_in,
  output logic [LANES*LANE_W-1:0] dq_out,
  output logic                    dq_oe
);
  localparam int DATA_W = LANES * LANE_W;

  logic              go;
  logic              sel_ok;
  op_e               op_cur;
  logic [ADDR_W-1:0] beat_addr;
  logic [LANES-1:0]  beat_be;
  logic              commit;
  logic              wb_pend;
  logic [ADDR_W-1:0] cm_addr;
  logic [LANES-1:0]  cm_be;
  logic [DATA_W-1:0] cm_data;
  logic [DATA_W-1:0] arr_q;

  assign go     = !cke_n && !sleep;
  assign sel_ok = !ce_a_n && ce_b && !ce_c_n;

  ftsram_cmd #(.ADDR_W(ADDR_W), .LANES(LANES)) u_cmd (
    .clk(clk), .rst(rst), .go(go), .adv_ld(adv_ld), .rd_wr(rd_wr),
    .sel_ok(sel_ok), .lin_burst(lin_burst), .addr(addr), .byte_we(byte_we),
    .op_q(op_cur), .cur_addr(beat_addr), .cur_be(beat_be)
  );

  ftsram_wbuf #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_wbuf (
    .clk(clk), .rst(rst), .go(go), .wr_beat(op_cur == OP_WRITE),
    .beat_addr(beat_addr), .beat_be(beat_be), .din(dq_in),
    .rd_addr(beat_addr), .arr_q(arr_q), .commit(commit), .pend(wb_pend),
    .cm_addr(cm_addr), .cm_be(cm_be), .cm_data(cm_data), .rd_data(dq_out)
  );

  ftsram_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk(clk), .we(commit), .waddr(cm_addr), .wbe(cm_be), .wdata(cm_data),
    .raddr(beat_addr), .rdata(arr_q)
  );

  assign dq_oe = (op_cur == OP_READ) && !oe_n && !sleep;
endmodule

// File: rtl/ftsram_chk.sv
`timescale 1ns/1ps
module ftsram_chk
  import ftsram_pkg::*;
(
  input logic clk,
  input logic rst,
  input logic cke_n,
  input logic sleep,
  input logic adv_ld,
  input logic rd_wr,
  input logic ce_a_n,
  input logic ce_b,
  input logic ce_c_n,
  input logic oe_n,
  input logic dq_oe,
  input op_e  op_cur,
  input logic wb_pend
);
  assert_reset_idle_R11: assert property (@(posedge clk)
    rst |=> (op_cur == OP_IDLE && !wb_pend));

  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (rst)
    (cke_n || sleep) |=> ($stable(op_cur) && $stable(wb_pend)));

  assert_load_read_R1: assert property (@(posedge clk) disable iff (rst)
    (!cke_n && !sleep && !adv_ld && !ce_a_n && ce_b && !ce_c_n && rd_wr)
      |=> op_cur == OP_READ);

  assert_load_write_R2: assert property (@(posedge clk) disable iff (rst)
    (!cke_n && !sleep && !adv_ld && !ce_a_n && ce_b && !ce_c_n && !rd_wr)
      |=> op_cur == OP_WRITE);

  assert_late_capture_R2: assert property (@(posedge clk) disable iff (rst)
    (!cke_n && !sleep && op_cur == OP_WRITE) |=> wb_pend);

  assert_deselect_R3: assert property (@(posedge clk) disable iff (rst)
    (!cke_n && !sleep && !adv_ld && (ce_a_n || !ce_b || ce_c_n))
      |=> op_cur == OP_IDLE);

  assert_burst_keep_R4: assert property (@(posedge clk) disable iff (rst)
    (!cke_n && !sleep && adv_ld) |=> op_cur == $past(op_cur));

  assert_oe_gate_R7: assert property (@(posedge clk) disable iff (rst)
    dq_oe |-> !oe_n);

  assert_sleep_quiet_R8: assert property (@(posedge clk) disable iff (rst)
    sleep |-> !dq_oe);
endmodule

bind ftsram_top ftsram_chk u_chk (
  .clk(clk), .rst(rst), .cke_n(cke_n), .sleep(sleep), .adv_ld(adv_ld),
  .rd_wr(rd_wr), .ce_a_n(ce_a_n), .ce_b(ce_b), .ce_c_n(ce_c_n),
  .oe_n(oe_n), .dq_oe(dq_oe), .op_cur(op_cur), .wb_pend(wb_pend)
);

// File: tb/ftsram_top_tb.sv
`timescale 1ns/1ps
module ftsram_top_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cke_n = 1'b0;
  logic [7:0]  addr = '0;
  logic        adv_ld = 1'b0;
  logic        rd_wr = 1'b1;
  logic [3:0]  byte_we = '0;
  logic        ce_a_n = 1'b1;
  logic        ce_b = 1'b1;
  logic        ce_c_n = 1'b0;
  logic        oe_n = 1'b0;
  logic        lin_burst = 1'b1;
  logic        sleep = 1'b0;
  logic [31:0] dq_in = '0;
  logic [31:0] dq_out;
  logic        dq_oe;

  ftsram_top u_dut (
    .clk(clk), .rst(rst), .cke_n(cke_n), .addr(addr), .adv_ld(adv_ld),
    .rd_wr(rd_wr), .byte_we(byte_we), .ce_a_n(ce_a_n), .ce_b(ce_b),
    .ce_c_n(ce_c_n), .oe_n(oe_n), .lin_burst(lin_burst), .sleep(sleep),
    .dq_in(dq_in), .dq_out(dq_out), .dq_oe(dq_oe)
  );

  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0;
  int fails = 0;

  typedef struct {
    int          cyc;
    bit          oe;
    logic [31:0] d;
    string       tag;
  } exp_t;
  exp_t sbq[$];

  // reference state built from the requirements
  logic [31:0] ref_mem [256];
  int          m_op = 0;          // 0 idle, 1 read, 2 write
  logic [7:0]  m_base = '0;
  logic [1:0]  m_cnt = '0;
  bit          m_pend = 0;
  logic [7:0]  m_paddr = '0;
  logic [3:0]  m_pbe = '0;

  function automatic logic [7:0] maddr();
    logic [1:0] lo;
    lo = lin_burst ? (m_base[1:0] + m_cnt) : (m_base[1:0] ^ m_cnt);
    return {m_base[7:2], lo};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic push_now(input string tag);
    exp_t e;
    e.cyc = cyc + 1;
    e.oe  = (m_op == 1);
    e.d   = (m_op == 1) ? ref_mem[maddr()] : '0;
    e.tag = tag;
    sbq.push_back(e);
  endtask

  // one clock of stimulus; din is the data for the previous write beat
  task automatic step(input bit adv, input bit rw, input logic [7:0] a, input logic [3:0] be,
                      input bit csok, input logic [31:0] din, input bit hold, input string tag);
    @(negedge clk);
    cke_n = hold; adv_ld = adv; rd_wr = rw; addr = a; byte_we = be;
    ce_a_n = !csok; ce_b = 1'b1; ce_c_n = 1'b0; dq_in = din;
    if (!hold) begin
      if (m_pend) begin
        for (int l = 0; l < 4; l++)
          if (m_pbe[l]) ref_mem[m_paddr][l*8 +: 8] = din[l*8 +: 8];
        m_pend = 0;
      end
      if (!adv) begin
        m_op = !csok ? 0 : (rw ? 1 : 2);
        m_base = a;
        m_cnt = '0;
      end else begin
        m_cnt = m_cnt + 2'd1;
      end
      if (m_op == 2) begin
        m_pend = 1; m_paddr = maddr(); m_pbe = be;
      end
    end
    push_now(tag);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(posedge clk);
      #1;
      while (sbq.size() > 0 && sbq[0].cyc <= cyc) begin
        exp_t e;
        e = sbq.pop_front();
        checks++;
        if (e.cyc != cyc || dq_oe !== e.oe || (e.oe && dq_out !== e.d)) begin
          fails++;
          $display("FAIL %s cycle %0d: dq_oe=%b dq_out=%h expected dq_oe=%b dq_out=%h",
                   e.tag, cyc, dq_oe, dq_out, e.oe, e.d);
        end
      end
    end
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #2000000;
    checks++; fails++;
    $display("FAIL watchdog expired actual=%0d expected=done", cyc);
    summary();
    $finish;
  end

  initial begin
    // R11: reset state
    repeat (3) @(negedge clk);
    rst = 1'b0;
    #1 chk(dq_oe === 1'b0, "R11 idle after reset", {31'b0, dq_oe}, 32'h0);

    // R2/R4/R5: linear write burst at 0x10, advance beats with rd_wr and selects flipped
    lin_burst = 1'b1;
    step(0, 0, 8'h10, 4'hF, 1, 32'h0,         0, "R2");
    step(1, 1, 8'h00, 4'hF, 0, 32'hA0A0_0010, 0, "R4");
    step(1, 0, 8'h00, 4'hF, 1, 32'hA0A0_0011, 0, "R5");
    step(1, 0, 8'h00, 4'hF, 1, 32'hA0A0_0012, 0, "R5");
    // R10/R5: read right after the write burst, linear from 0x12
    step(0, 1, 8'h12, 4'h0, 1, 32'hA0A0_0013, 0, "R10");
    step(1, 0, 8'h00, 4'h0, 0, 32'h0, 0, "R5 linear");
    step(1, 0, 8'h00, 4'h0, 0, 32'h0, 0, "R5 linear");
    step(1, 0, 8'h00, 4'h0, 0, 32'h0, 0, "R5 linear");
    // R3: deselect, then interleaved read burst from 0x13
    step(0, 1, 8'h00, 4'h0, 0, 32'h0, 0, "R3");
    lin_burst = 1'b0;
    step(0, 1, 8'h13, 4'h0, 1, 32'h0, 0, "R1");
    step(1, 1, 8'h00, 4'h0, 1, 32'h0, 0, "R5 interleaved");
    step(1, 1, 8'h00, 4'h0, 1, 32'h0, 0, "R5 interleaved");
    step(1, 1, 8'h00, 4'h0, 1, 32'h0, 0, "R5 interleaved");

    // R9: partial write then immediate read of the same word
    step(0, 0, 8'h20, 4'hF,    1, 32'h0,         0, "R2");
    step(0, 0, 8'h20, 4'b0101, 1, 32'h1111_1111, 0, "R2");
    step(0, 1, 8'h20, 4'h0,    1, 32'h2222_2222, 0, "R9 merge");
    step(0, 1, 8'h20, 4'h0,    1, 32'h0,         0, "R9 after commit");

    // R10: alternating writes and reads
    step(0, 0, 8'h30, 4'hF,    1, 32'h0,         0, "R10");
    step(0, 1, 8'h10, 4'h0,    1, 32'h3030_3030, 0, "R10");
    step(0, 0, 8'h31, 4'hF,    1, 32'h0,         0, "R10");
    step(0, 1, 8'h30, 4'h0,    1, 32'h3131_3131, 0, "R10");
    step(0, 0, 8'h30, 4'b1000, 1, 32'h0,         0, "R10");
    step(0, 1, 8'h31, 4'h0,    1, 32'h5500_0000, 0, "R10");
    step(0, 1, 8'h30, 4'h0,    1, 32'h0,         0, "R10 byte lane 3");

    // R6: stall holds a read and defers write data capture
    step(0, 1, 8'h20, 4'h0, 1, 32'h0,         0, "R6");
    step(0, 0, 8'h20, 4'hF, 1, 32'hDEAD_DEAD, 1, "R6 stalled read holds");
    step(0, 0, 8'h40, 4'hF, 1, 32'h0,         0, "R6");
    step(0, 0, 8'h41, 4'hF, 1, 32'hBAD0_BAD0, 1, "R6 stalled write");
    step(0, 1, 8'h40, 4'h0, 1, 32'h4444_4444, 0, "R6 deferred capture");
    step(0, 1, 8'h20, 4'h0, 1, 32'h0,         0, "R6 stalled write ignored");

    // R3: deselected write leaves memory alone; R4: deselect continues through advance
    step(0, 0, 8'h10, 4'hF, 0, 32'h0,         0, "R3");
    step(0, 1, 8'h10, 4'h0, 1, 32'h7777_7777, 0, "R3 no write");
    step(0, 1, 8'h10, 4'h0, 0, 32'h0,         0, "R3");
    step(1, 1, 8'h10, 4'h0, 1, 32'h0,         0, "R4 deselect burst");

    // R7: asynchronous output enable during a read
    step(0, 1, 8'h11, 4'h0, 1, 32'h0, 0, "R1");
    @(posedge clk); #2;
    oe_n = 1'b1;
    #1 chk(dq_oe === 1'b0, "R7 oe_n high releases bus", {31'b0, dq_oe}, 32'h0);
    oe_n = 1'b0;
    #1 chk(dq_oe === 1'b1, "R7 oe_n low drives bus", {31'b0, dq_oe}, 32'h1);

    // R8: sleep releases bus, ignores edges, keeps data
    step(0, 1, 8'h12, 4'h0, 1, 32'h0, 0, "R1");
    @(posedge clk); #2;
    sleep = 1'b1;
    #1 chk(dq_oe === 1'b0, "R8 sleep releases bus", {31'b0, dq_oe}, 32'h0);
    @(negedge clk);
    cke_n = 1'b0; adv_ld = 1'b0; rd_wr = 1'b0; addr = 8'h12; byte_we = 4'hF;
    ce_a_n = 1'b0; dq_in = 32'hDEAD_BEEF;
    @(negedge clk);
    adv_ld = 1'b1; dq_in = 32'hFEED_FACE;
    @(negedge clk);
    sleep = 1'b0; cke_n = 1'b1;
    @(posedge clk); #1;
    chk(dq_oe === 1'b1, "R8 read resumes after sleep", {31'b0, dq_oe}, 32'h1);
    chk(dq_out === ref_mem[8'h12], "R8 data kept through sleep", dq_out, ref_mem[8'h12]);
    step(0, 1, 8'h12, 4'h0, 1, 32'h0, 0, "R8 sleep write ignored");
    step(0, 1, 8'h00, 4'h0, 0, 32'h0, 0, "R3");

    repeat (3) @(posedge clk);
    #2;
    summary();
    $finish;
  end
endmodule